// File: doc/BRIEF.md
# UART Register Front-End on a Word-Spaced APB Map

This block is the bus-facing control section of a classic byte-oriented UART. It decodes APB accesses into a small register set. Each register occupies its own 32-bit word, and only the low byte of each word carries data. Through this register set, software configures the character format and the baud divisor, pushes transmit bytes, pops received bytes, reads line status and selects which events raise the interrupt line.

The serial shifters, the baud generator and the FIFOs are outside the block. It reaches them through plain ports:
- a receive occupancy count, head byte and head parity flag, and a pop strobe;
- a transmit push strobe and data, a transmit-empty flag and a shifter-idle flag;
- FIFO enable and clear strobes;
- the 16-bit divisor, which the external generator turns into a bit clock of `clk / (16 × divisor)`.

Every APB access completes in its access phase.

Top module: `apb_uart_regs`

## Requirements
- R1: The register index is taken from `paddr[4:2]`, so register n sits at byte offset 4·n. Address bits [1:0] and the bits above bit 4 have no effect on which register is accessed. Read data occupies `prdata[7:0]`, and `prdata[31:8]` is always zero.
- R2: When line-control bit 7 is 0, an APB read of offset 0 returns `rx_data` and pulses `rx_pop` during its access phase, but only if `rx_level` is nonzero. An APB write to offset 0 pulses `tx_push` with `tx_data = pwdata[7:0]`.
- R3: When line-control bit 7 is 1, offset 0 reads and writes the divisor low byte and offset 4 reads and writes the divisor high byte. In this mode neither `rx_pop` nor `tx_push` pulses, and the interrupt-enable value is untouched. The `divisor` output is {high, low}.
- R4: When line-control bit 7 is 0, offset 4 holds a 3-bit interrupt enable in bits [2:0], and its bits [7:3] read as zero.
- R5: A write to offset 8 (FIFO control) stores bit 0 as `fifo_en`. Bit 1 raises `rx_clr` and bit 2 raises `tx_clr`, each for exactly the one cycle after the write.
- R6: FIFO-control bits [7:6] select the receive trigger level: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. The trigger condition is `rx_level >= level` when `fifo_en` is 1, and `rx_level != 0` when `fifo_en` is 0.
- R7: Offset 12 (line control) reads back as written. Bits [1:0] drive `data_bits`, bit 2 drives `two_stop` and bit 3 drives `parity_en`.
- R8: Offset 20 (line status) reads {0, tx_empty & tx_idle, tx_empty, 0, 0, rx_perr & rx_valid, 0, rx_valid}, where `rx_valid` means `rx_level != 0`.
- R9: `irq` is high when any enabled source is active:
  - enable bit 0 with the trigger condition or `rx_timeout`;
  - enable bit 1 with `tx_empty`;
  - enable bit 2 with `line_err`.

  A read of offset 8 returns {fifo_en, fifo_en, 0, 0, id[2:0], ~irq}. The id is chosen by this priority: line error 011, receive trigger 010, timeout 110, transmit empty 001, none 000.
- R10: Offsets 16, 24 and 28 read as zero, and writes to them change no state. `pready` is always 1 and `pslverr` is always 0.
- R11: After reset, line control is 0x03, the interrupt enable is 0, the divisor is 1, `fifo_en` is 1, the trigger level is 1 entry, and both clear strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| rx_level | input | LVL_W | Receive FIFO occupancy |
| rx_data | input | 8 | Receive FIFO head byte |
| rx_perr | input | 1 | Parity error on the head byte |
| rx_timeout | input | 1 | Character timeout indication |
| line_err | input | 1 | Overrun, parity, framing or break error |
| rx_pop | output | 1 | Pop the receive head |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_idle | input | 1 | Transmit shifter idle |
| tx_push | output | 1 | Push a byte to the transmit FIFO |
| tx_data | output | 8 | Byte to push |
| fifo_en | output | 1 | FIFO mode enable |
| rx_clr | output | 1 | One-cycle receive FIFO clear |
| tx_clr | output | 1 | One-cycle transmit FIFO clear |
| data_bits | output | 2 | Character length code |
| two_stop | output | 1 | Extra stop bit select |
| parity_en | output | 1 | Parity enable |
| divisor | output | 16 | Baud divisor {high, low} |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with `ADDR_W = 12` and `LVL_W = 5`. A 5-bit occupancy count lets the bench drive receive levels on both sides of every trigger threshold, including 13 versus 14. A 12-bit address lets it put nonzero values in bits [1:0] and reach all eight word slots, including the unused ones. The bench also sweeps the interrupt sources one at a time with all enables set, so that each identification code and its priority is seen.

// File: rtl/apb_uart_regs.sv
module apb_uart_regs #(
  parameter int ADDR_W = 12,
  parameter int LVL_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic [7:0]        rx_data,
  input  logic              rx_perr,
  input  logic              rx_timeout,
  input  logic              line_err,
  output logic              rx_pop,
  input  logic              tx_empty,
  input  logic              tx_idle,
  output logic              tx_push,
  output logic [7:0]        tx_data,
  output logic              fifo_en,
  output logic              rx_clr,
  output logic              tx_clr,
  output logic [1:0]        data_bits,
  output logic              two_stop,
  output logic              parity_en,
  output logic [15:0]       divisor,
  output logic              irq
);
  localparam int IDX_W = 3;

  logic [7:0] lcr, div_lo, div_hi;
  logic [2:0] ier;
  logic [1:0] trig_sel;
  logic [IDX_W-1:0] idx;
  logic acc, wr, rd, dlab, rx_valid, rx_trig;
  logic src_err, src_rx, src_to, src_tx;
  logic [2:0] iid;
  logic [7:0] rbyte;
  int unsigned trig_lvl;

  assign idx     = paddr[4:2];
  assign acc     = psel && penable;
  assign wr      = acc && pwrite;
  assign rd      = acc && !pwrite;
  assign dlab    = lcr[7];
  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  assign rx_valid = rx_level != '0;
  assign rx_pop   = rd && idx == 3'd0 && !dlab && rx_valid;
  assign tx_push  = wr && idx == 3'd0 && !dlab;
  assign tx_data  = pwdata[7:0];

  assign data_bits = lcr[1:0];
  assign two_stop  = lcr[2];
  assign parity_en = lcr[3];
  assign divisor   = {div_hi, div_lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr      <= 8'h03;
      ier      <= '0;
      div_lo   <= 8'h01;
      div_hi   <= 8'h00;
      fifo_en  <= 1'b1;
      trig_sel <= 2'b00;
      rx_clr   <= 1'b0;
      tx_clr   <= 1'b0;
    end else begin
      rx_clr <= 1'b0;
      tx_clr <= 1'b0;
      if (wr) begin
        case (idx)
          3'd0: if (dlab) div_lo <= pwdata[7:0];
          3'd1: if (dlab) div_hi <= pwdata[7:0]; else ier <= pwdata[2:0];
          3'd2: begin
            fifo_en  <= pwdata[0];
            rx_clr   <= pwdata[1];
            tx_clr   <= pwdata[2];
            trig_sel <= pwdata[7:6];
          end
          3'd3: lcr <= pwdata[7:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (trig_sel)
      2'b00:   trig_lvl = 1;
      2'b01:   trig_lvl = 4;
      2'b10:   trig_lvl = 8;
      default: trig_lvl = 14;
    endcase
  end

  assign rx_trig = fifo_en ? (32'(rx_level) >= trig_lvl) : rx_valid;
  assign src_err = ier[2] && line_err;
  assign src_rx  = ier[0] && rx_trig;
  assign src_to  = ier[0] && rx_timeout;
  assign src_tx  = ier[1] && tx_empty;
  assign irq     = src_err || src_rx || src_to || src_tx;

  always_comb begin
    if (src_err)     iid = 3'b011;
    else if (src_rx) iid = 3'b010;
    else if (src_to) iid = 3'b110;
    else if (src_tx) iid = 3'b001;
    else             iid = 3'b000;
  end

  always_comb begin
    case (idx)
      3'd0:    rbyte = dlab ? div_lo : rx_data;
      3'd1:    rbyte = dlab ? div_hi : {5'b0, ier};
      3'd2:    rbyte = {fifo_en, fifo_en, 2'b00, iid, ~irq};
      3'd3:    rbyte = lcr;
      3'd5:    rbyte = {1'b0, tx_empty && tx_idle, tx_empty, 2'b00,
                        rx_perr && rx_valid, 1'b0, rx_valid};
      default: rbyte = 8'h00;
    endcase
  end
  assign prdata = {24'h0, rbyte};

  logic unused_bits;
  assign unused_bits = ^{pwdata[31:8], paddr[1:0], paddr[ADDR_W-1:5], pwdata[5:3]};

  p_pop_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> rx_level != '0);
  p_push_dlab_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |-> !lcr[7]);
  p_div_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(psel && penable && pwrite) |=> $stable(divisor));
  p_clr_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_clr || tx_clr) |=> !(rx_clr || tx_clr));
  p_irq_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ier == 3'b000) |-> !irq);
  p_idle_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_empty && rd && idx == 3'd5) |-> prdata[6:5] == 2'b00);
endmodule

// File: tb/apb_uart_regs_test.sv
module apb_uart_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int LVL_W  = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [ADDR_W-1:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic pready, pslverr;
  logic [LVL_W-1:0] rx_level = '0;
  logic [7:0] rx_data = '0;
  logic rx_perr = 0, rx_timeout = 0, line_err = 0, tx_empty = 0, tx_idle = 0;
  logic rx_pop, tx_push, fifo_en, rx_clr, tx_clr, two_stop, parity_en, irq;
  logic [7:0] tx_data;
  logic [1:0] data_bits;
  logic [15:0] divisor;

  int total = 0, bad = 0;
  logic seen_push, seen_pop, seen_ok;
  logic [7:0] seen_txd;
  logic [1:0] clr1, clr2;
  logic [31:0] rdv;

  apb_uart_regs #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) uut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .rx_level(rx_level), .rx_data(rx_data), .rx_perr(rx_perr),
    .rx_timeout(rx_timeout), .line_err(line_err), .rx_pop(rx_pop),
    .tx_empty(tx_empty), .tx_idle(tx_idle), .tx_push(tx_push), .tx_data(tx_data),
    .fifo_en(fifo_en), .rx_clr(rx_clr), .tx_clr(tx_clr), .data_bits(data_bits),
    .two_stop(two_stop), .parity_en(parity_en), .divisor(divisor), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic apb_wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1;
    #1;
    seen_push = tx_push; seen_pop = rx_pop; seen_txd = tx_data;
    seen_ok = pready && !pslverr;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
    clr1 = {rx_clr, tx_clr};
    @(negedge clk);
    clr2 = {rx_clr, tx_clr};
  endtask

  task automatic apb_rd(logic [ADDR_W-1:0] a);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk);
    penable = 1;
    #1;
    rdv = prdata; seen_pop = rx_pop; seen_push = tx_push;
    seen_ok = pready && !pslverr;
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  task automatic t_reset;
    apb_rd(12'h00C); check("R11 lcr", rdv, 32'h03);
    apb_rd(12'h004); check("R11 ier", rdv, 32'h00);
    check("R11 divisor", 32'(divisor), 32'h1);
    check("R11 fifo_en", 32'(fifo_en), 32'h1);
    check("R11 clr", 32'({rx_clr, tx_clr}), 32'h0);
    check("R11 irq", 32'(irq), 32'h0);
  endtask

  task automatic t_decode_lcr;
    apb_wr(12'hF0D, 32'hFFFF_FF1F);
    apb_rd(12'h00E); check("R1 lcr alias", rdv, 32'h1F);
    check("R7 data_bits", 32'(data_bits), 32'h3);
    check("R7 two_stop", 32'(two_stop), 32'h1);
    check("R7 parity_en", 32'(parity_en), 32'h1);
    apb_wr(12'h00C, 32'h02);
    check("R7 data_bits 7", 32'(data_bits), 32'h2);
    check("R7 parity off", 32'(parity_en), 32'h0);
    apb_wr(12'h00C, 32'h03);
  endtask

  task automatic t_data;
    rx_level = 5'd3; rx_data = 8'hA5;
    apb_rd(12'h000);
    check("R2 rx byte", rdv, 32'hA5); check("R2 pop", 32'(seen_pop), 32'h1);
    rx_level = 5'd0;
    apb_rd(12'h000); check("R2 no pop empty", 32'(seen_pop), 32'h0);
    apb_wr(12'h000, 32'h0000_005A);
    check("R2 push", 32'(seen_push), 32'h1); check("R2 tx_data", 32'(seen_txd), 32'h5A);
  endtask

  task automatic t_divisor;
    apb_wr(12'h00C, 32'h83);
    apb_wr(12'h000, 32'h34); check("R3 no push", 32'(seen_push), 32'h0);
    apb_wr(12'h004, 32'h12);
    check("R3 divisor", 32'(divisor), 32'h1234);
    rx_level = 5'd2;
    apb_rd(12'h000); check("R3 read lo", rdv, 32'h34); check("R3 no pop", 32'(seen_pop), 32'h0);
    apb_rd(12'h004); check("R3 read hi", rdv, 32'h12);
    rx_level = 5'd0;
    apb_wr(12'h00C, 32'h03);
    apb_rd(12'h004); check("R3 ier untouched", rdv, 32'h00);
    check("R3 divisor kept", 32'(divisor), 32'h1234);
  endtask

  task automatic t_ier;
    tx_empty = 0;
    apb_wr(12'h004, 32'hFF);
    apb_rd(12'h004); check("R4 ier bits", rdv, 32'h07);
    apb_wr(12'h004, 32'h00);
  endtask

  task automatic t_fcr;
    apb_wr(12'h008, 32'h06);
    check("R5 clr pulse", 32'(clr1), 32'h3);
    check("R5 clr self", 32'(clr2), 32'h0);
    check("R5 fifo off", 32'(fifo_en), 32'h0);
    apb_wr(12'h008, 32'h03);
    check("R5 rx clr only", 32'(clr1), 32'h2);
    check("R5 fifo on", 32'(fifo_en), 32'h1);
  endtask

  task automatic lvl(logic [LVL_W-1:0] l, logic exp, string req);
    @(negedge clk); rx_level = l; #1;
    check(req, 32'(irq), 32'(exp));
  endtask

  task automatic t_trigger;
    tx_empty = 0; line_err = 0; rx_timeout = 0;
    apb_wr(12'h004, 32'h01);
    apb_wr(12'h008, 32'h01);
    lvl(0, 0, "R6 lvl1 empty"); lvl(1, 1, "R6 lvl1 hit");
    apb_wr(12'h008, 32'h41);
    lvl(3, 0, "R6 lvl4 below"); lvl(4, 1, "R6 lvl4 hit");
    apb_wr(12'h008, 32'h81);
    lvl(7, 0, "R6 lvl8 below"); lvl(8, 1, "R6 lvl8 hit");
    apb_wr(12'h008, 32'hC1);
    lvl(13, 0, "R6 lvl14 below"); lvl(14, 1, "R6 lvl14 hit");
    apb_wr(12'h008, 32'hC0);
    lvl(1, 1, "R6 nofifo any");
    apb_wr(12'h008, 32'hC1);
    lvl(0, 0, "R6 cleared");
  endtask

  task automatic t_lsr;
    rx_level = 2; rx_perr = 1; tx_empty = 1; tx_idle = 0;
    apb_rd(12'h014); check("R8 lsr a", rdv, 32'h25);
    rx_level = 0; rx_perr = 1; tx_idle = 1;
    apb_rd(12'h014); check("R8 lsr b", rdv, 32'h60);
    rx_perr = 0; tx_empty = 0; tx_idle = 0;
  endtask

  task automatic t_iir;
    apb_wr(12'h004, 32'h00);
    apb_rd(12'h008); check("R9 iir none", rdv, 32'hC1);
    apb_wr(12'h004, 32'h07);
    line_err = 1; rx_timeout = 1; tx_empty = 1; rx_level = 14;
    apb_rd(12'h008); check("R9 iir err", rdv, 32'hC6);
    check("R9 irq", 32'(irq), 32'h1);
    line_err = 0;
    apb_rd(12'h008); check("R9 iir rx", rdv, 32'hC4);
    rx_level = 0;
    apb_rd(12'h008); check("R9 iir timeout", rdv, 32'hCC);
    rx_timeout = 0;
    apb_rd(12'h008); check("R9 iir txe", rdv, 32'hC2);
    apb_wr(12'h004, 32'h02); tx_empty = 0; #1;
    check("R9 irq off", 32'(irq), 32'h0);
    apb_wr(12'h004, 32'h00);
  endtask

  task automatic t_unused;
    apb_wr(12'h010, 32'hFF); check("R10 ok", 32'(seen_ok), 32'h1);
    apb_wr(12'h018, 32'hFF);
    apb_wr(12'h01C, 32'hFF);
    apb_rd(12'h010); check("R10 off16", rdv, 32'h0);
    apb_rd(12'h018); check("R10 off24", rdv, 32'h0);
    apb_rd(12'h01C); check("R10 off28", rdv, 32'h0);
    check("R10 rd ok", 32'(seen_ok), 32'h1);
    apb_rd(12'h00C); check("R10 lcr kept", rdv, 32'h03);
    apb_rd(12'h004); check("R10 ier kept", rdv, 32'h00);
    check("R10 div kept", 32'(divisor), 32'h1234);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_decode_lcr;
    t_data;
    t_divisor;
    t_ier;
    t_fcr;
    t_trigger;
    t_lsr;
    t_iir;
    t_unused;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule